// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Register

This block holds the status word of one serial expansion channel. It keeps three interrupt sources, each as a mask and a flag: expansion events, transfer completion and external events. It also holds a clock-rate selection, a chip-select field, a ROM-disable control and a device-present indication. Software writes the word through a simple write strobe and reads the composed value back combinationally. Hardware events set the flags. Writing a one to a flag bit clears that flag.

Which bits software may change depends on the `CHAN_ID` parameter. The external-event pair can be written only on channels 0 and 1. ROM disable can be written only on channel 0. Channel 2 always reports the device as absent. Any write that alters the chip-select field is reported to the attached devices one cycle later. A two-state tracker handles this report. It moves from `CS_IDLE` to `CS_REPORT` on a write that changes chip select, stays in `CS_REPORT` while further changing writes arrive, and returns to `CS_IDLE` on any other cycle. The interrupt output is asserted whenever any flag is set while its mask is set.

Top module: `chan_status_reg`

## Requirements
- R1: After reset, all masks, flags, the clock field, chip select and ROM disable are 0, and `irq` and `cs_notify` are low.
- R2: A write stores bit 0 as the expansion mask. Writing 1 to bit 1 clears the expansion flag. A high `exp_event` sets that flag.
- R3: A write stores bit 2 as the transfer-complete mask. Writing 1 to bit 3 clears the transfer-complete flag. A high `xfer_done` sets that flag.
- R4: On channels 0 and 1, a write stores bit 10 as the external mask, and writing 1 to bit 11 clears the external flag. On channel 2 these bits have no effect. On every channel, `ext_event` sets the external flag at bit 11.
- R5: Bit 13 (ROM disable) is stored on channel 0 only. Other channels always read it as 0.
- R6: Every write stores bits 6:4 as the clock-rate field. The field reads back on the same bits from the cycle after the write.
- R7: Bit 12 of `rd_data` equals `dev_present` on channels 0 and 1, and is 0 on channel 2.
- R8: Every write stores bits 9:7 as chip select, visible on `cs_sel` and on `rd_data[9:7]`. In the cycle after a write that changes chip select, `cs_notify` is high and `cs_delta` is old XOR new. Otherwise `cs_notify` is low.
- R9: `irq` is high exactly when some flag is set together with its mask. The pairs are bits 0/1, 2/3 and 10/11.
- R10: If a hardware set and a write-one clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | DATA_W | Write data |
| dev_present | input | 1 | Slot-1 device present |
| xfer_done | input | 1 | Transfer finished; sets the transfer-complete flag |
| ext_event | input | 1 | External event; sets the external flag |
| exp_event | input | 1 | Expansion event; sets the expansion flag |
| rd_data | output | DATA_W | Composed status word |
| irq | output | 1 | Combined masked interrupt |
| cs_sel | output | CS_W | Current chip select |
| cs_notify | output | 1 | Chip-select change report, valid one cycle |
| cs_delta | output | CS_W | Chip-select lines that changed |

## Verification
The bench drives channel variants 0, 1 and 2 side by side with the same stimulus. This exposes any write-enable gating tied to the wrong channel number: a faulty channel 2 would let its external mask raise an interrupt, and a faulty channel 1 would keep ROM disable. A hardware set that coincides with a write-one clear is checked directly. A design that gives the clear priority would lose a completion interrupt. Writes that repeat the current chip select must produce no report, and a report must carry the XOR of old and new values, not the new value alone. Random writes and event pulses with a fixed seed then compare the full word and `irq` against a bench model every cycle.

// File: rtl/chan_status_pkg.sv
package chan_status_pkg;
    localparam int NUM_PAIRS = 3;
    localparam int CLK_W     = 3;
    localparam int CS_W      = 3;
    localparam int CLK_LSB   = 4;
    localparam int CS_LSB    = 7;
    localparam int PRES_BIT  = 12;
    localparam int ROM_BIT   = 13;
    localparam int USED_W    = 14;

    typedef enum logic {
        CS_IDLE,
        CS_REPORT
    } cs_state_e;

    // pair 0: expansion, pair 1: transfer complete, pair 2: external
    function automatic int mask_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            default: return 10;
        endcase
    endfunction

    function automatic int flag_pos(input int idx);
        return mask_pos(idx) + 1;
    endfunction
endpackage

// File: rtl/irq_pair.sv
module irq_pair #(
    parameter bit WRITABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_mask,
    input  logic wr_clr,
    input  logic hw_set,
    output logic mask_q,
    output logic flag_q
);
    logic wr_ok;
    assign wr_ok = WRITABLE & wr_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ok)
                mask_q <= wr_mask;
            if (hw_set)
                flag_q <= 1'b1;
            else if (wr_ok && wr_clr)
                flag_q <= 1'b0;
        end
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> flag_q);
endmodule

// File: rtl/cs_tracker.sv
module cs_tracker #(
    parameter int CS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CS_W-1:0] wr_cs,
    output logic [CS_W-1:0] cs_q,
    output logic            cs_notify,
    output logic [CS_W-1:0] cs_delta
);
    import chan_status_pkg::*;

    cs_state_e state_q, state_d;
    logic      change;

    assign change = wr_en && (wr_cs != cs_q);

    always_comb begin
        state_d = CS_IDLE;
        unique case (state_q)
            CS_IDLE:   state_d = change ? CS_REPORT : CS_IDLE;
            CS_REPORT: state_d = change ? CS_REPORT : CS_IDLE;
            default:   state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CS_IDLE;
            cs_q     <= '0;
            cs_delta <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en)
                cs_q <= wr_cs;
            if (change)
                cs_delta <= cs_q ^ wr_cs;
        end
    end

    always_comb begin
        cs_notify = 1'b0;
        unique case (state_q)
            CS_IDLE:   cs_notify = 1'b0;
            CS_REPORT: cs_notify = 1'b1;
            default:   cs_notify = 1'b0;
        endcase
    end

    a_r8_notify_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cs_notify |-> ($past(wr_en) && cs_delta != '0));
endmodule

// File: rtl/chan_status_reg.sv
module chan_status_reg
    import chan_status_pkg::*;
#(
    parameter int CHAN_ID = 0,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dev_present,
    input  logic              xfer_done,
    input  logic              ext_event,
    input  logic              exp_event,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic [CS_W-1:0]   cs_sel,
    output logic              cs_notify,
    output logic [CS_W-1:0]   cs_delta
);
    localparam bit EXT_WR = (CHAN_ID < 2);
    localparam bit ROM_WR = (CHAN_ID == 0);
    localparam bit PRES_ON = (CHAN_ID != 2);

    logic [NUM_PAIRS-1:0] mask_v, flag_v, set_v;
    logic [CLK_W-1:0]     clk_q;
    logic                 rom_q;
    logic                 unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:USED_W];
    assign set_v = {ext_event, xfer_done, exp_event};

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        localparam bit WR_OK = (i == 2) ? EXT_WR : 1'b1;
        irq_pair #(.WRITABLE(WR_OK)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_mask(wr_data[mask_pos(i)]),
            .wr_clr (wr_data[flag_pos(i)]),
            .hw_set (set_v[i]),
            .mask_q (mask_v[i]),
            .flag_q (flag_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= '0;
            rom_q <= 1'b0;
        end else if (wr_en) begin
            clk_q <= wr_data[CLK_LSB +: CLK_W];
            if (ROM_WR)
                rom_q <= wr_data[ROM_BIT];
        end
    end

    cs_tracker #(.CS_W(CS_W)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_cs    (wr_data[CS_LSB +: CS_W]),
        .cs_q     (cs_sel),
        .cs_notify(cs_notify),
        .cs_delta (cs_delta)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            rd_data[mask_pos(i)] = mask_v[i];
            rd_data[flag_pos(i)] = flag_v[i];
        end
        rd_data[CLK_LSB +: CLK_W] = clk_q;
        rd_data[CS_LSB +: CS_W]   = cs_sel;
        rd_data[PRES_BIT]         = PRES_ON & dev_present;
        rd_data[ROM_BIT]          = rom_q;
    end

    assign irq = |(mask_v & flag_v);

    a_r9_irq_matches_word: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((rd_data[0] & rd_data[1]) | (rd_data[2] & rd_data[3]) |
                (rd_data[10] & rd_data[11])));

    a_r6_clock_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[CLK_LSB +: CLK_W] == $past(wr_data[CLK_LSB +: CLK_W]));

    a_r3_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3] && !xfer_done) |=> !rd_data[3]);

    a_r5_rom_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (CHAN_ID != 0) |-> !rd_data[ROM_BIT]);
endmodule

// File: tb/chan_status_reg_bench.sv
module chan_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        dev_present = 1'b0;
    logic        xfer_done = 1'b0;
    logic        ext_event = 1'b0;
    logic        exp_event = 1'b0;

    logic [31:0] rd [3];
    logic        irq [3];
    logic [2:0]  csl [3];
    logic        ntf [3];
    logic [2:0]  dlt [3];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    chan_status_reg #(.CHAN_ID(0)) u_chan_status_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dev_present(dev_present), .xfer_done(xfer_done), .ext_event(ext_event),
        .exp_event(exp_event), .rd_data(rd[0]), .irq(irq[0]), .cs_sel(csl[0]),
        .cs_notify(ntf[0]), .cs_delta(dlt[0]));
    chan_status_reg #(.CHAN_ID(1)) u_chan_status_reg_ch1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dev_present(dev_present), .xfer_done(xfer_done), .ext_event(ext_event),
        .exp_event(exp_event), .rd_data(rd[1]), .irq(irq[1]), .cs_sel(csl[1]),
        .cs_notify(ntf[1]), .cs_delta(dlt[1]));
    chan_status_reg #(.CHAN_ID(2)) u_chan_status_reg_ch2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dev_present(dev_present), .xfer_done(xfer_done), .ext_event(ext_event),
        .exp_event(exp_event), .rd_data(rd[2]), .irq(irq[2]), .cs_sel(csl[2]),
        .cs_notify(ntf[2]), .cs_delta(dlt[2]));

    // bench model, one entry per channel
    logic       m_em [3], m_ef [3], m_tm [3], m_tf [3], m_xm [3], m_xf [3];
    logic       m_rom [3], m_ntf [3];
    logic [2:0] m_clk [3], m_cs [3], m_dlt [3];

    function automatic logic [31:0] exp_word(input int c);
        logic [31:0] w = '0;
        w[0] = m_em[c]; w[1] = m_ef[c]; w[2] = m_tm[c]; w[3] = m_tf[c];
        w[6:4] = m_clk[c]; w[9:7] = m_cs[c];
        w[10] = m_xm[c]; w[11] = m_xf[c];
        w[12] = (c != 2) && dev_present;
        w[13] = m_rom[c];
        return w;
    endfunction

    function automatic logic exp_irq(input int c);
        return (m_em[c] & m_ef[c]) | (m_tm[c] & m_tf[c]) | (m_xm[c] & m_xf[c]);
    endfunction

    task automatic chk(input string tag, input int c, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s ch%0d: actual %h expected %h", tag, c, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_em[c] = 0; m_ef[c] = 0; m_tm[c] = 0; m_tf[c] = 0;
            m_xm[c] = 0; m_xf[c] = 0; m_rom[c] = 0; m_ntf[c] = 0;
            m_clk[c] = 0; m_cs[c] = 0; m_dlt[c] = 0;
        end
    endtask

    task automatic model_step();
        for (int c = 0; c < 3; c++) begin
            logic w1 = wr_en;
            m_ef[c] = exp_event ? 1'b1 : (w1 && wr_data[1]) ? 1'b0 : m_ef[c];
            m_tf[c] = xfer_done ? 1'b1 : (w1 && wr_data[3]) ? 1'b0 : m_tf[c];
            m_xf[c] = ext_event ? 1'b1 : (w1 && wr_data[11] && c < 2) ? 1'b0 : m_xf[c];
            m_ntf[c] = 1'b0;
            if (w1) begin
                m_em[c] = wr_data[0];
                m_tm[c] = wr_data[2];
                if (c < 2) m_xm[c] = wr_data[10];
                if (c == 0) m_rom[c] = wr_data[13];
                m_clk[c] = wr_data[6:4];
                if (wr_data[9:7] != m_cs[c]) begin
                    m_ntf[c] = 1'b1;
                    m_dlt[c] = m_cs[c] ^ wr_data[9:7];
                end
                m_cs[c] = wr_data[9:7];
            end
        end
    endtask

    task automatic compare(input string tag);
        for (int c = 0; c < 3; c++) begin
            chk({tag, " word"}, c, rd[c], exp_word(c));
            chk({tag, " R9 irq"}, c, {31'b0, irq[c]}, {31'b0, exp_irq(c)});
            chk({tag, " R8 notify"}, c, {31'b0, ntf[c]}, {31'b0, m_ntf[c]});
            chk({tag, " R8 cs_sel"}, c, {29'b0, csl[c]}, {29'b0, m_cs[c]});
            if (m_ntf[c])
                chk({tag, " R8 delta"}, c, {29'b0, dlt[c]}, {29'b0, m_dlt[c]});
        end
    endtask

    // drive at negedge, clock once, check at next negedge
    task automatic step(input string tag, input logic w, input logic [31:0] d,
                        input logic pres, input logic xd, input logic ee, input logic xe);
        wr_en = w; wr_data = d; dev_present = pres;
        xfer_done = xd; ext_event = ee; exp_event = xe;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 0; xfer_done = 0; ext_event = 0; exp_event = 0;
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        dev_present = 1'b1;
        @(negedge clk);
        compare("R1 reset");
        for (int c = 0; c < 3; c++)
            chk("R1 irq low", c, {31'b0, irq[c]}, 32'h0);

        // R2: event sets flag, mask enables irq, write-one clears
        step("R2 set", 0, 0, 1, 0, 0, 1);
        step("R2 mask", 1, 32'h1, 1, 0, 0, 0);
        step("R2 clear", 1, 32'h3, 1, 0, 0, 0);
        // R3: transfer done and clear
        step("R3 set", 1, 32'h4, 1, 1, 0, 0);
        step("R3 clear", 1, 32'hC, 1, 0, 0, 0);
        // R10: set and clear in the same cycle
        step("R10 collide", 1, 32'hC, 1, 1, 0, 0);
        // R4: external pair, ignored on ch2
        step("R4 set", 0, 0, 1, 0, 1, 0);
        step("R4 mask", 1, 32'h400, 1, 0, 0, 0);
        step("R4 clear", 1, 32'hC00, 1, 0, 0, 0);
        // R5: rom disable
        step("R5 rom", 1, 32'h2000, 1, 0, 0, 0);
        // R6: clock field
        step("R6 clk", 1, 32'h50, 1, 0, 0, 0);
        // R7: presence toggled
        step("R7 absent", 0, 0, 0, 0, 0, 0);
        step("R7 present", 0, 0, 1, 0, 0, 0);
        // R8: chip-select change then repeat then change again
        step("R8 change", 1, 32'h080, 1, 0, 0, 0);
        step("R8 repeat", 1, 32'h080, 1, 0, 0, 0);
        step("R8 change2", 1, 32'h300, 1, 0, 0, 0);
        step("R8 idle", 0, 0, 1, 0, 0, 0);

        void'($urandom(32'd1234));
        for (int n = 0; n < 500; n++) begin
            logic [31:0] d = $urandom & 32'h3FFF;
            int r = $urandom % 4;
            step("R6 random", r != 0, d, ($urandom % 3) != 0,
                 ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule